// File: doc/BRIEF.md
# CAN Transmit Status and Error Warning Register Bank

This block holds the software-visible status and error-warning state of one CAN controller channel that has three transmit buffers. An 8-bit warning limit is compared on every clock against the transmit and receive error counters. The result drives a registered error status flag and a one-cycle error warning interrupt. Software can change the limit only while the channel is held in reset mode. The flag and the interrupt stay frozen until reset mode is left, so a new limit has no effect before then.

For each transmit buffer the block tracks two flags. The lock flag is 0 while a message is pending or being sent. The complete flag is 1 once a requested transmission has finished successfully. While its lock flag is 0, a buffer's message word cannot be written. The status word packs one byte per buffer and repeats the receive-side flags in every byte. The register port uses word addresses: 0 is the limit, 1 is the status word, and 2, 3 and 4 are the message words of buffers 0, 1 and 2. Reads are combinational, and any other address reads 0.

Top module: `cantx_status_regs`

## Requirements
- R1: After reset the warning limit is 0x60. It reads back at address 0, in bits 7:0, at any time, whatever the state of reset mode.
- R2: A write to address 0 updates the limit on the next clock only when `resetMode` is 1. With `resetMode` at 0 the write leaves the limit unchanged.
- R3: While `resetMode` is 0, `errStatus` becomes 1 one clock after either error counter is greater than or equal to the limit. It becomes 0 one clock after both counters are below the limit.
- R4: While `resetMode` is 1, `errStatus` holds its value and `errWarnIrq` stays 0, whatever the counters and the limit do.
- R5: `errWarnIrq` is 1 for exactly one cycle, in the same cycle that `errStatus` rises from 0 to 1.
- R6: Status byte k (bits 8k+7:8k) holds the receive buffer flag in bit 0, the overrun flag in bit 1, the lock flag of buffer k in bit 2 (1 = released), the complete flag of buffer k in bit 3, and the receive-active flag in bit 4. Bits 7:5 and bits 31:24 are 0. After reset both buffer flags are 1 in every byte.
- R7: A `txReq` strobe clears both the lock flag and the complete flag of its buffer. A `txDone` strobe sets both. A `txAbort` strobe sets the lock flag only. When strobes for one buffer arrive in the same cycle, `txReq` wins over `txDone`, and `txDone` wins over `txAbort`. Each change shows up one clock after the strobe.
- R8: A write to the message word of buffer k (address 2+k) takes effect only while that buffer's lock flag is 1. Writes made while it is locked are dropped. The word resets to 0.
- R9: The receive-side bits of the status word follow `rxBufStat`, `dataOverrun` and `rxActive` combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| resetMode | input | 1 | Channel is in reset (configuration) mode |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational |
| txErrCnt | input | 8 | Transmit error counter |
| rxErrCnt | input | 8 | Receive error counter |
| rxBufStat | input | 1 | Receive buffer holds a message |
| dataOverrun | input | 1 | Receive data overrun flag |
| rxActive | input | 1 | Receiver is busy with a frame |
| txReq | input | 3 | Per-buffer transmission request strobes |
| txDone | input | 3 | Per-buffer successful completion strobes |
| txAbort | input | 3 | Per-buffer abort strobes |
| errStatus | output | 1 | Error status flag |
| errWarnIrq | output | 1 | Error warning interrupt pulse |

## Verification
A wrong lock or complete flag shows in the status word on the read port one clock after the offending strobe. It also shows as a dropped or accepted message-word write that reads back wrong at once. A corrupted limit, or one changed outside reset mode, shows within one cycle as a wrong value at address 0. The flag then moves at the wrong counter value: the limit-minus-one and exact-limit counter values expose an off-by-one compare in the next cycle. A missed freeze in reset mode shows as `errStatus` moving, or `errWarnIrq` pulsing, in the very cycle after the counters cross the limit while the mode is still set.

// File: rtl/cantx_stat_pkg.sv
package cantx_stat_pkg;
  localparam int ADDR_LIMIT = 0;
  localparam int ADDR_STAT  = 1;
  localparam int ADDR_BUF0  = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic limWr;    // accepted limit write
    logic errEval;  // error status may be re-evaluated this cycle
  } ctrlStrb_t;
endpackage

// File: rtl/cantx_stat_ctrl.sv
module cantx_stat_ctrl
  import cantx_stat_pkg::*;
#(
  parameter int NBUF   = 3,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resetMode,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [NBUF-1:0]   txReq,
  input  logic [NBUF-1:0]   txDone,
  input  logic [NBUF-1:0]   txAbort,
  output ctrlStrb_t         strb,
  output logic [NBUF-1:0]   bufWr,
  output logic [NBUF-1:0]   lockBits,
  output logic [NBUF-1:0]   cmplBits
);
  always_comb begin
    strb.limWr   = regWrEn && (regAddr == ADDR_W'(ADDR_LIMIT)) && resetMode;
    strb.errEval = !resetMode;
  end

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    logic lockQ, cmplQ;

    // writes reach the message word only while released
    assign bufWr[b] = regWrEn && (regAddr == ADDR_W'(ADDR_BUF0 + b)) && lockQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lockQ <= 1'b1;
        cmplQ <= 1'b1;
      end else if (txReq[b]) begin
        lockQ <= 1'b0;
        cmplQ <= 1'b0;
      end else if (txDone[b]) begin
        lockQ <= 1'b1;
        cmplQ <= 1'b1;
      end else if (txAbort[b]) begin
        lockQ <= 1'b1;
      end
    end

    assign lockBits[b] = lockQ;
    assign cmplBits[b] = cmplQ;
  end
endmodule

// File: rtl/cantx_stat_dp.sv
module cantx_stat_dp
  import cantx_stat_pkg::*;
#(
  parameter int NBUF      = 3,
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 8,
  parameter logic [CNT_W-1:0] LIM_RESET = CNT_W'(96)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [NBUF-1:0]   bufWr,
  input  logic [NBUF-1:0]   lockBits,
  input  logic [NBUF-1:0]   cmplBits,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [CNT_W-1:0]  txErrCnt,
  input  logic [CNT_W-1:0]  rxErrCnt,
  input  logic              rxBufStat,
  input  logic              dataOverrun,
  input  logic              rxActive,
  output logic [DATA_W-1:0] regRdData,
  output logic [CNT_W-1:0]  limitVal,
  output logic              errStatus,
  output logic              errWarnIrq
);
  localparam int STAT_W = 8 * NBUF;

  logic [CNT_W-1:0]  limitQ;
  logic [DATA_W-1:0] bufMem [NBUF];
  logic [STAT_W-1:0] statWord;
  logic              overLim;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            limitQ <= LIM_RESET;
    else if (strb.limWr)  limitQ <= regWrData[CNT_W-1:0];
  end

  assign overLim = (txErrCnt >= limitQ) || (rxErrCnt >= limitQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errStatus  <= 1'b0;
      errWarnIrq <= 1'b0;
    end else begin
      errWarnIrq <= strb.errEval && overLim && !errStatus;
      if (strb.errEval) errStatus <= overLim;
    end
  end

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         bufMem[b] <= '0;
      else if (bufWr[b]) bufMem[b] <= regWrData;
    end
    assign statWord[8*b +: 8] = {3'b000, rxActive, cmplBits[b], lockBits[b],
                                 dataOverrun, rxBufStat};
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(ADDR_LIMIT))
      regRdData = DATA_W'(limitQ);
    else if (regAddr == ADDR_W'(ADDR_STAT))
      regRdData = DATA_W'(statWord);
    else
      for (int b = 0; b < NBUF; b++)
        if (regAddr == ADDR_W'(ADDR_BUF0 + b)) regRdData = bufMem[b];
  end

  assign limitVal = limitQ;
endmodule

// File: rtl/cantx_status_regs.sv
module cantx_status_regs
  import cantx_stat_pkg::*;
#(
  parameter int NBUF   = 3,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resetMode,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [CNT_W-1:0]  txErrCnt,
  input  logic [CNT_W-1:0]  rxErrCnt,
  input  logic              rxBufStat,
  input  logic              dataOverrun,
  input  logic              rxActive,
  input  logic [NBUF-1:0]   txReq,
  input  logic [NBUF-1:0]   txDone,
  input  logic [NBUF-1:0]   txAbort,
  output logic              errStatus,
  output logic              errWarnIrq
);
  ctrlStrb_t        strb;
  logic [NBUF-1:0]  bufWr, lockBits, cmplBits;
  logic [CNT_W-1:0] limitVal;

  cantx_stat_ctrl #(.NBUF(NBUF), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .resetMode(resetMode), .regWrEn(regWrEn),
    .regAddr(regAddr), .txReq(txReq), .txDone(txDone), .txAbort(txAbort),
    .strb(strb), .bufWr(bufWr), .lockBits(lockBits), .cmplBits(cmplBits)
  );

  cantx_stat_dp #(.NBUF(NBUF), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .bufWr(bufWr), .lockBits(lockBits),
    .cmplBits(cmplBits), .regAddr(regAddr), .regWrData(regWrData),
    .txErrCnt(txErrCnt), .rxErrCnt(rxErrCnt), .rxBufStat(rxBufStat),
    .dataOverrun(dataOverrun), .rxActive(rxActive), .regRdData(regRdData),
    .limitVal(limitVal), .errStatus(errStatus), .errWarnIrq(errWarnIrq)
  );
endmodule

// File: rtl/cantx_stat_chk.sv
module cantx_stat_chk #(
  parameter int NBUF  = 3,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             resetMode,
  input logic [CNT_W-1:0] limitVal,
  input logic [NBUF-1:0]  txReq,
  input logic [NBUF-1:0]  txDone,
  input logic [NBUF-1:0]  txAbort,
  input logic [NBUF-1:0]  lockBits,
  input logic [NBUF-1:0]  cmplBits,
  input logic             errStatus,
  input logic             errWarnIrq
);
  // R2
  lim_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resetMode |=> $stable(limitVal));

  // R4
  es_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetMode |=> $stable(errStatus));

  // R4
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetMode |=> !errWarnIrq);

  // R5
  irq_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    errWarnIrq |=> !errWarnIrq);

  // R5
  irq_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    errWarnIrq |-> $rose(errStatus));

  for (genvar b = 0; b < NBUF; b++) begin : g_buf
    // R7
    req_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      txReq[b] |=> (!lockBits[b] && !cmplBits[b]));
    // R7
    done_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      (txDone[b] && !txReq[b]) |=> (lockBits[b] && cmplBits[b]));
    // R7
    abort_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
      (txAbort[b] && !txReq[b] && !txDone[b]) |=> (lockBits[b] && $stable(cmplBits[b])));
  end
endmodule

bind cantx_status_regs cantx_stat_chk #(.NBUF(NBUF), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .resetMode(resetMode), .limitVal(limitVal),
  .txReq(txReq), .txDone(txDone), .txAbort(txAbort), .lockBits(lockBits),
  .cmplBits(cmplBits), .errStatus(errStatus), .errWarnIrq(errWarnIrq)
);

// File: tb/cantx_status_regs_tb.sv
module cantx_status_regs_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resetMode = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [7:0]  txErrCnt = '0, rxErrCnt = '0;
  logic        rxBufStat = 1'b0, dataOverrun = 1'b0, rxActive = 1'b0;
  logic [2:0]  txReq = '0, txDone = '0, txAbort = '0;
  logic        errStatus, errWarnIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit reported = 1'b0;

  always #10 clk = ~clk;

  cantx_status_regs dut_i (
    .clk(clk), .rstN(rstN), .resetMode(resetMode), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .txErrCnt(txErrCnt), .rxErrCnt(rxErrCnt), .rxBufStat(rxBufStat),
    .dataOverrun(dataOverrun), .rxActive(rxActive), .txReq(txReq),
    .txDone(txDone), .txAbort(txAbort), .errStatus(errStatus),
    .errWarnIrq(errWarnIrq)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic writeReg(logic [2:0] a, logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    end
  endtask

  task automatic testReset();
    logic [31:0] d;
    readReg(3'd0, d); check("R1 limit reset", d, 32'h60);
    readReg(3'd1, d); check("R6 status reset", d, 32'h000C0C0C);
    check("R3 errStatus reset", {31'd0, errStatus}, 32'd0);
    check("R5 irq reset", {31'd0, errWarnIrq}, 32'd0);
    readReg(3'd5, d); check("R8 unmapped address", d, 32'd0);
  endtask

  task automatic testLimitWrite();
    logic [31:0] d;
    resetMode = 1'b0;
    writeReg(3'd0, 32'h22);
    readReg(3'd0, d); check("R2 write outside reset mode ignored", d, 32'h60);
    resetMode = 1'b1;
    writeReg(3'd0, 32'h10);
    readReg(3'd0, d); check("R2 write in reset mode", d, 32'h10);
    readReg(3'd0, d); check("R1 limit readable in reset mode", d, 32'h10);
  endtask

  task automatic testErrStatus();
    txErrCnt = 8'h20;
    tick();
    check("R4 errStatus frozen", {31'd0, errStatus}, 32'd0);
    check("R4 no irq in reset mode", {31'd0, errWarnIrq}, 32'd0);
    resetMode = 1'b0;
    tick();
    check("R3 tx over limit", {31'd0, errStatus}, 32'd1);
    check("R5 irq on rise", {31'd0, errWarnIrq}, 32'd1);
    txErrCnt = 8'h00; rxErrCnt = 8'h10;
    tick();
    check("R5 irq one cycle", {31'd0, errWarnIrq}, 32'd0);
    check("R3 rx equal limit", {31'd0, errStatus}, 32'd1);
    rxErrCnt = 8'h0F;
    tick();
    check("R3 below limit clears", {31'd0, errStatus}, 32'd0);
    rxErrCnt = 8'h10;
    tick();
    check("R3 rx reaches limit", {31'd0, errStatus}, 32'd1);
    check("R5 second rise irq", {31'd0, errWarnIrq}, 32'd1);
    resetMode = 1'b1; rxErrCnt = 8'h00;
    tick();
    tick();
    check("R4 errStatus held high in reset mode", {31'd0, errStatus}, 32'd1);
    resetMode = 1'b0;
    tick();
    check("R3 clears after leaving reset mode", {31'd0, errStatus}, 32'd0);
  endtask

  task automatic testTxBuffers();
    logic [31:0] d;
    txReq = 3'b010;
    tick();
    txReq = 3'b000;
    readReg(3'd1, d); check("R7 request locks buffer 1", d, 32'h000C000C);
    writeReg(3'd3, 32'hDEADBEEF);
    readReg(3'd3, d); check("R8 locked write dropped", d, 32'h0);
    writeReg(3'd2, 32'h12345678);
    readReg(3'd2, d); check("R8 released write accepted", d, 32'h12345678);
    txDone = 3'b010;
    tick();
    txDone = 3'b000;
    readReg(3'd1, d); check("R7 done releases buffer 1", d, 32'h000C0C0C);
    writeReg(3'd3, 32'hCAFE0001);
    readReg(3'd3, d); check("R8 write after release", d, 32'hCAFE0001);
    txReq = 3'b100;
    tick();
    txReq = 3'b000; txAbort = 3'b100;
    tick();
    txAbort = 3'b000;
    readReg(3'd1, d); check("R7 abort sets lock only", d, 32'h00040C0C);
    txReq = 3'b001; txDone = 3'b001;
    tick();
    txReq = 3'b000; txDone = 3'b000;
    readReg(3'd1, d); check("R7 request wins over done", d, 32'h00040C00);
    txDone = 3'b001; txAbort = 3'b001;
    tick();
    txDone = 3'b000; txAbort = 3'b000;
    readReg(3'd1, d); check("R7 done wins over abort", d, 32'h00040C0C);
  endtask

  task automatic testRxMirror();
    logic [31:0] d;
    rxBufStat = 1'b1; dataOverrun = 1'b1;
    readReg(3'd1, d); check("R9 rx and overrun mirror", d, 32'h00070F0F);
    rxActive = 1'b1; rxBufStat = 1'b0;
    readReg(3'd1, d); check("R9 rx active mirror R6 layout", d, 32'h00161E1E);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    testReset();
    testLimitWrite();
    testErrStatus();
    testTxBuffers();
    testRxMirror();
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end
endmodule